// File: doc/BRIEF.md
# Matrix Tile Shape Configuration Unit

This block keeps the shape description for a bank of eight matrix tile registers. Software-visible configuration arrives as a 64-byte image, streamed in over a port of `BEAT_BYTES` bytes per beat. The unit decodes the image as it arrives and validates it once the final beat has been taken. It then either adopts the new shape or reports a fault and keeps the shape it already had. Downstream tile logic reads a row count and a row width in bytes for each tile, plus one flag that says whether the bank is configured.

Two events return the unit to its init state, where nothing is configured and every shape field reads zero. The first is an accepted image whose palette byte is zero. The second is an explicit release command. Either event raises a one-cycle clear request so that the tile data storage wipes itself. A store request streams the live configuration back out in the same image format. Once a palette-1 image has been accepted, the store returns that image unchanged. In the init state the store returns only zero bytes.

Top module: `tile_cfg_unit`

## Requirements
- R1: An image is `64/BEAT_BYTES` beats qualified by `ld_valid`, and lane k of beat n carries image byte `n*BEAT_BYTES+k` on `ld_data[8k+7:8k]`. In the cycle after the final beat, exactly one of `ld_done` (accepted) or `ld_fault` (rejected) is high for one cycle.
- R2: After an accepted image with palette byte (byte 0) equal to 1, `cfg_valid` is 1 and tile t reports row width {byte 17+2t, byte 16+2t} on `tile_colsb[16t+15:16t]` and row count byte 48+t on `tile_rows[8t+7:8t]`. Byte 1 is the start row.
- R3: An image whose palette byte is greater than 1 is rejected.
- R4: An image with any nonzero byte in 2..15, 32..47 or 56..63 is rejected.
- R5: A palette-1 image with any row width above 64 or any row count above 16 is rejected. Values exactly at these limits are accepted.
- R6: A rejected image leaves `cfg_valid`, `tile_rows` and `tile_colsb` unchanged, and `ld_fault` is never high together with `ld_done`.
- R7: An accepted palette-0 image puts the unit in init: `cfg_valid` is 0, all shape outputs are 0, and `clear_tiles` is high for one cycle. Row width and row count limits are not applied to a palette-0 image.
- R8: A `rel_cmd` cycle puts the unit in init in the next cycle and raises `clear_tiles` there.
- R9: A `st_start` while idle makes `st_valid` high for `64/BEAT_BYTES` cycles starting in the next cycle. Those cycles carry the image in load order, `st_last` marks the final one, and after an accepted palette-1 image the bytes equal that image.
- R10: A store in the init state returns 64 zero bytes.
- R11: After synchronous reset, `cfg_valid`, all shape outputs, `ld_done`, `ld_fault`, `clear_tiles` and `st_valid` are 0.
- R12: When `rel_cmd` coincides with the final beat of an image, the release wins: the unit ends in init with `clear_tiles` high, and the image is still reported as accepted or rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load beat qualifier |
| ld_data | input | 8*BEAT_BYTES | Load beat, byte lanes in image order |
| rel_cmd | input | 1 | Release to init state |
| st_start | input | 1 | Start streaming the live image out |
| st_valid | output | 1 | Store beat qualifier |
| st_data | output | 8*BEAT_BYTES | Store beat, same lane order as loads |
| st_last | output | 1 | Final store beat |
| ld_done | output | 1 | Image accepted pulse |
| ld_fault | output | 1 | Image rejected pulse |
| cfg_valid | output | 1 | Tiles configured |
| clear_tiles | output | 1 | Request to zero all tile data |
| tile_rows | output | 64 | Row count per tile, tile t at bits 8t+7:8t |
| tile_colsb | output | 128 | Row width in bytes per tile, tile t at bits 16t+15:16t |

## Verification
The hardest situation to reach is a release landing in exactly the cycle that carries the final beat of an image. That is the one place where the release and the commit race for the same registers. The bench drives this directly, with both a valid image and an invalid one, so that it can check both the release priority and the fault report. A second case is hard to reach because row widths and row counts are only checked after the palette byte is known, which arrives many beats earlier. Random images are therefore corrupted in only one place each: the palette, a single reserved byte, or a single tile limit pushed just past its bound. Directed images also sit exactly at the limits, and a palette-0 image with out-of-range shapes shows that the limit rule applies only to palette 1.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;
  localparam int IMG_BYTES  = 64;
  localparam int NUM_TILES  = 8;
  localparam int COLSB_BASE = 16;
  localparam int ROWS_BASE  = 48;

  typedef struct packed {
    logic [7:0]                      pal;
    logic [7:0]                      srow;
    logic [NUM_TILES-1:0][15:0]      colsb;
    logic [NUM_TILES-1:0][7:0]       rows;
  } tcfg_img_t;

  // Byte i of the image as serialised from a decoded configuration.
  function automatic logic [7:0] img_byte(tcfg_img_t f, int i);
    logic [7:0] b;
    logic [2:0] t;
    b = 8'h00;
    t = 3'd0;
    if (i == 0) begin
      b = f.pal;
    end else if (i == 1) begin
      b = f.srow;
    end else if (i >= COLSB_BASE && i < COLSB_BASE + 2*NUM_TILES) begin
      t = 3'((i - COLSB_BASE) / 2);
      b = ((i % 2) == 0) ? f.colsb[t][7:0] : f.colsb[t][15:8];
    end else if (i >= ROWS_BASE && i < ROWS_BASE + NUM_TILES) begin
      t = 3'(i - ROWS_BASE);
      b = f.rows[t];
    end
    return b;
  endfunction
endpackage

// File: rtl/tcfg_ingest.sv
module tcfg_ingest
  import tcfg_pkg::*;
#(
  parameter int BEAT_BYTES = 1,
  parameter int MAX_COLSB  = 64,
  parameter int MAX_ROWS   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_valid,
  input  logic [8*BEAT_BYTES-1:0] ld_data,
  output logic                    fin,
  output logic                    fin_ok,
  output tcfg_img_t               fin_img
);
  localparam int BEATS = IMG_BYTES / BEAT_BYTES;
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LASTB = CW'(BEATS - 1);

  logic [CW-1:0] beat_q;
  tcfg_img_t     stage_q, nxt;
  logic          res_q, res_cur, res_nxt, lim_bad;

  generate
    if (BEATS > 1) begin : g_cnt
      always_ff @(posedge clk) begin
        if (rst)                beat_q <= '0;
        else if (ld_valid)      beat_q <= (beat_q == LASTB) ? '0 : beat_q + CW'(1);
      end
    end else begin : g_single
      assign beat_q = '0;
    end
  endgenerate

  // Merge the current beat into the staged fields; flag reserved bytes.
  always_comb begin
    nxt     = stage_q;
    res_cur = 1'b0;
    for (int k = 0; k < BEAT_BYTES; k++) begin
      int         i;
      logic [7:0] b;
      i = int'(beat_q) * BEAT_BYTES + k;
      b = ld_data[8*k +: 8];
      if (i == 0) begin
        nxt.pal = b;
      end else if (i == 1) begin
        nxt.srow = b;
      end else if (i >= COLSB_BASE && i < COLSB_BASE + 2*NUM_TILES) begin
        if ((i % 2) == 0) nxt.colsb[3'((i - COLSB_BASE) / 2)][7:0]  = b;
        else              nxt.colsb[3'((i - COLSB_BASE) / 2)][15:8] = b;
      end else if (i >= ROWS_BASE && i < ROWS_BASE + NUM_TILES) begin
        nxt.rows[3'(i - ROWS_BASE)] = b;
      end else if (b != 8'h00) begin
        res_cur = 1'b1;
      end
    end
  end

  assign res_nxt = ((beat_q == '0) ? 1'b0 : res_q) | res_cur;

  always_comb begin
    lim_bad = 1'b0;
    for (int t = 0; t < NUM_TILES; t++) begin
      if (int'(nxt.colsb[t]) > MAX_COLSB) lim_bad = 1'b1;
      if (int'(nxt.rows[t])  > MAX_ROWS)  lim_bad = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      res_q   <= 1'b0;
    end else if (ld_valid) begin
      stage_q <= nxt;
      res_q   <= res_nxt;
    end
  end

  assign fin     = ld_valid && (beat_q == LASTB);
  assign fin_img = nxt;
  assign fin_ok  = !res_nxt &&
                   ((nxt.pal == 8'd0) || ((nxt.pal == 8'd1) && !lim_bad));
endmodule

// File: rtl/tcfg_regs.sv
module tcfg_regs
  import tcfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      fin,
  input  logic      fin_ok,
  input  tcfg_img_t fin_img,
  input  logic      rel_cmd,
  output tcfg_img_t live,
  output logic      cfg_valid,
  output logic      ld_done,
  output logic      ld_fault,
  output logic      clear_tiles
);
  always_ff @(posedge clk) begin
    if (rst) begin
      live        <= '0;
      cfg_valid   <= 1'b0;
      ld_done     <= 1'b0;
      ld_fault    <= 1'b0;
      clear_tiles <= 1'b0;
    end else begin
      ld_done     <= fin && fin_ok;
      ld_fault    <= fin && !fin_ok;
      clear_tiles <= 1'b0;
      if (rel_cmd) begin
        live        <= '0;
        cfg_valid   <= 1'b0;
        clear_tiles <= 1'b1;
      end else if (fin && fin_ok) begin
        if (fin_img.pal == 8'd0) begin
          live        <= '0;
          cfg_valid   <= 1'b0;
          clear_tiles <= 1'b1;
        end else begin
          live      <= fin_img;
          cfg_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tcfg_emit.sv
module tcfg_emit
  import tcfg_pkg::*;
#(
  parameter int BEAT_BYTES = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    st_start,
  input  tcfg_img_t               live,
  output logic                    st_valid,
  output logic [8*BEAT_BYTES-1:0] st_data,
  output logic                    st_last
);
  localparam int BEATS = IMG_BYTES / BEAT_BYTES;
  localparam int CW    = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [CW-1:0] LASTB = CW'(BEATS - 1);

  logic [CW-1:0]           nb_q, sel_beat;
  logic [8*BEAT_BYTES-1:0] word;
  logic                    busy;

  assign busy     = st_valid && !st_last;
  assign sel_beat = busy ? nb_q : '0;

  generate
    for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_lane
      assign word[8*k +: 8] = img_byte(live, int'(sel_beat) * BEAT_BYTES + k);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      st_valid <= 1'b0;
      st_last  <= 1'b0;
      st_data  <= '0;
      nb_q     <= '0;
    end else if (busy) begin
      st_data <= word;
      st_last <= (nb_q == LASTB);
      nb_q    <= nb_q + CW'(1);
    end else if (st_start) begin
      st_valid <= 1'b1;
      st_data  <= word;
      st_last  <= (LASTB == '0);
      nb_q     <= CW'(1);
    end else begin
      st_valid <= 1'b0;
      st_last  <= 1'b0;
      st_data  <= '0;
    end
  end
endmodule

// File: rtl/tile_cfg_unit.sv
module tile_cfg_unit
  import tcfg_pkg::*;
#(
  parameter int BEAT_BYTES = 1,
  parameter int MAX_COLSB  = 64,
  parameter int MAX_ROWS   = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_valid,
  input  logic [8*BEAT_BYTES-1:0] ld_data,
  input  logic                    rel_cmd,
  input  logic                    st_start,
  output logic                    st_valid,
  output logic [8*BEAT_BYTES-1:0] st_data,
  output logic                    st_last,
  output logic                    ld_done,
  output logic                    ld_fault,
  output logic                    cfg_valid,
  output logic                    clear_tiles,
  output logic [8*NUM_TILES-1:0]  tile_rows,
  output logic [16*NUM_TILES-1:0] tile_colsb
);
  logic      fin, fin_ok;
  tcfg_img_t fin_img, live;

  tcfg_ingest #(
    .BEAT_BYTES(BEAT_BYTES), .MAX_COLSB(MAX_COLSB), .MAX_ROWS(MAX_ROWS)
  ) u_ingest (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_data(ld_data),
    .fin(fin), .fin_ok(fin_ok), .fin_img(fin_img)
  );

  tcfg_regs u_regs (
    .clk(clk), .rst(rst), .fin(fin), .fin_ok(fin_ok), .fin_img(fin_img),
    .rel_cmd(rel_cmd), .live(live), .cfg_valid(cfg_valid),
    .ld_done(ld_done), .ld_fault(ld_fault), .clear_tiles(clear_tiles)
  );

  tcfg_emit #(.BEAT_BYTES(BEAT_BYTES)) u_emit (
    .clk(clk), .rst(rst), .st_start(st_start), .live(live),
    .st_valid(st_valid), .st_data(st_data), .st_last(st_last)
  );

  generate
    for (genvar t = 0; t < NUM_TILES; t++) begin : g_shape
      assign tile_rows[8*t +: 8]   = live.rows[t];
      assign tile_colsb[16*t +: 16] = live.colsb[t];
    end
  endgenerate
endmodule

// File: rtl/tile_cfg_unit_chk.sv
module tile_cfg_unit_chk #(
  parameter int BEAT_BYTES = 1,
  parameter int MAX_COLSB  = 64,
  parameter int MAX_ROWS   = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    rel_cmd,
  input logic                    st_valid,
  input logic [8*BEAT_BYTES-1:0] st_data,
  input logic                    st_last,
  input logic                    ld_done,
  input logic                    ld_fault,
  input logic                    cfg_valid,
  input logic                    clear_tiles,
  input logic [63:0]             tile_rows,
  input logic [127:0]            tile_colsb
);
  logic lim_ok;
  always_comb begin
    lim_ok = 1'b1;
    for (int t = 0; t < 8; t++) begin
      if (int'(tile_rows[8*t +: 8])    > MAX_ROWS)  lim_ok = 1'b0;
      if (int'(tile_colsb[16*t +: 16]) > MAX_COLSB) lim_ok = 1'b0;
    end
  end

  AST_DONE_FAULT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ld_done && ld_fault)); // R6
  AST_FAULT_KEEPS_CFG: assert property (@(posedge clk) disable iff (rst)
    (ld_fault && !$past(rel_cmd)) |-> ($stable(cfg_valid) && $stable(tile_rows) && $stable(tile_colsb))); // R6
  AST_RELEASE_INIT: assert property (@(posedge clk) disable iff (rst)
    rel_cmd |=> (!cfg_valid && clear_tiles)); // R8
  AST_CLEAR_IS_INIT: assert property (@(posedge clk) disable iff (rst)
    clear_tiles |-> (!cfg_valid && tile_rows == '0 && tile_colsb == '0)); // R7
  AST_SHAPE_LIMITS: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> lim_ok); // R5
  AST_UNCFG_STORE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !$past(cfg_valid)) |-> (st_data == '0)); // R10
  AST_LAST_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    st_last |-> st_valid); // R9
endmodule

bind tile_cfg_unit tile_cfg_unit_chk #(
  .BEAT_BYTES(BEAT_BYTES), .MAX_COLSB(MAX_COLSB), .MAX_ROWS(MAX_ROWS)
) u_chk (.*);

// File: tb/tile_cfg_unit_test.sv
`timescale 1ns/1ps
module tile_cfg_unit_test;
  localparam int BB    = 4;
  localparam int W     = 8 * BB;
  localparam int BEATS = 64 / BB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ld_valid = 1'b0;
  logic [W-1:0]  ld_data = '0;
  logic          rel_cmd = 1'b0;
  logic          st_start = 1'b0;
  logic          st_valid, st_last, ld_done, ld_fault, cfg_valid, clear_tiles;
  logic [W-1:0]  st_data;
  logic [63:0]   tile_rows;
  logic [127:0]  tile_colsb;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [7:0] cur  [64];
  logic [7:0] mimg [64];
  bit         mcfg = 1'b0;

  always #2 clk = ~clk;

  tile_cfg_unit #(.BEAT_BYTES(BB)) uut (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_data(ld_data),
    .rel_cmd(rel_cmd), .st_start(st_start), .st_valid(st_valid),
    .st_data(st_data), .st_last(st_last), .ld_done(ld_done),
    .ld_fault(ld_fault), .cfg_valid(cfg_valid), .clear_tiles(clear_tiles),
    .tile_rows(tile_rows), .tile_colsb(tile_colsb)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic bit img_ok();
    for (int i = 0; i < 64; i++)
      if (((i >= 2 && i < 16) || (i >= 32 && i < 48) || i >= 56) && cur[i] != 0) return 1'b0;
    if (cur[0] > 1) return 1'b0;
    if (cur[0] == 1)
      for (int t = 0; t < 8; t++)
        if ({cur[17+2*t], cur[16+2*t]} > 16'd64 || cur[48+t] > 8'd16) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model_init();
    mcfg = 1'b0;
    for (int i = 0; i < 64; i++) mimg[i] = 8'h00;
  endtask

  task automatic check_cfg(input string tag);
    logic [63:0]  er;
    logic [127:0] ec;
    for (int t = 0; t < 8; t++) begin
      er[8*t +: 8]   = mimg[48+t];
      ec[16*t +: 16] = {mimg[17+2*t], mimg[16+2*t]};
    end
    chk(cfg_valid == mcfg, {tag, " cfg_valid"}, cfg_valid, mcfg);
    chk(tile_rows == er, {tag, " rows"}, tile_rows, er);
    chk(tile_colsb == ec, {tag, " colsb"}, tile_colsb, ec);
  endtask

  task automatic send(input bit rel_last, input string tag);
    bit ok;
    bit eclr;
    ok = img_ok();
    for (int b = 0; b < BEATS; b++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      for (int k = 0; k < BB; k++) ld_data[8*k +: 8] = cur[b*BB + k];
      rel_cmd = rel_last && (b == BEATS - 1);
    end
    @(negedge clk);
    ld_valid = 1'b0;
    rel_cmd  = 1'b0;
    eclr = 1'b0;
    if (rel_last) begin
      model_init();
      eclr = 1'b1;
    end else if (ok) begin
      if (cur[0] == 0) begin
        model_init();
        eclr = 1'b1;
      end else begin
        mcfg = 1'b1;
        for (int i = 0; i < 64; i++) mimg[i] = cur[i];
      end
    end
    chk(ld_done == ok, {tag, " done"}, ld_done, ok);
    chk(ld_fault == !ok, {tag, " fault"}, ld_fault, !ok);
    chk(clear_tiles == eclr, {tag, " clear"}, clear_tiles, eclr);
    check_cfg(tag);
  endtask

  task automatic do_store(input string tag);
    logic [W-1:0] ew;
    @(negedge clk);
    st_start = 1'b1;
    @(negedge clk);
    st_start = 1'b0;
    for (int b = 0; b < BEATS; b++) begin
      if (b > 0) @(negedge clk);
      for (int k = 0; k < BB; k++) ew[8*k +: 8] = mcfg ? mimg[b*BB + k] : 8'h00;
      chk(st_valid && st_data == ew && st_last == (b == BEATS - 1), {tag, " store beat"},
          {st_valid, st_last, st_data}, {1'b1, b == BEATS - 1, ew});
    end
    @(negedge clk);
    chk(!st_valid, {tag, " store end"}, st_valid, 0);
  endtask

  task automatic mk_valid();
    for (int i = 0; i < 64; i++) cur[i] = 8'h00;
    cur[0] = 8'd1;
    cur[1] = 8'($urandom);
    for (int t = 0; t < 8; t++) begin
      logic [15:0] c;
      c = 16'($urandom_range(64, 0));
      cur[16+2*t] = c[7:0];
      cur[17+2*t] = c[15:8];
      cur[48+t]   = 8'($urandom_range(16, 0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_init();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(!cfg_valid && tile_rows == 0 && tile_colsb == 0, "R11 shape", {cfg_valid, tile_rows}, 0);
    chk(!ld_done && !ld_fault && !clear_tiles && !st_valid, "R11 pulses",
        {ld_done, ld_fault, clear_tiles, st_valid}, 0);

    do_store("R10 after reset");

    // R2/R5 boundary: every tile at its limits
    for (int i = 0; i < 64; i++) cur[i] = 8'h00;
    cur[0] = 1; cur[1] = 8'h5a;
    for (int t = 0; t < 8; t++) begin cur[16+2*t] = 8'd64; cur[48+t] = 8'd16; end
    send(1'b0, "R2 R5 at limits");
    do_store("R9 roundtrip limits");

    mk_valid(); send(1'b0, "R1 R2 directed");
    do_store("R9 roundtrip");

    mk_valid(); cur[16+2*7] = 8'd65; send(1'b0, "R5 R6 colsb 65");
    mk_valid(); cur[17] = 8'd1; cur[16] = 8'd0; send(1'b0, "R5 R6 colsb high byte");
    mk_valid(); cur[48+3] = 8'd17; send(1'b0, "R5 R6 rows 17");
    mk_valid(); cur[0] = 8'd2; send(1'b0, "R3 palette 2");
    mk_valid(); cur[0] = 8'hff; send(1'b0, "R3 palette ff");
    mk_valid(); cur[63] = 8'd1; send(1'b0, "R4 byte 63");
    mk_valid(); cur[2] = 8'h80; send(1'b0, "R4 byte 2");
    mk_valid(); cur[40] = 8'h01; send(1'b0, "R4 byte 40");
    do_store("R6 R9 store after faults");

    // R7 palette 0 with out-of-range shapes is still init
    mk_valid(); cur[0] = 8'd0; cur[16] = 8'd200; cur[48] = 8'd99;
    send(1'b0, "R7 palette 0");
    @(negedge clk);
    chk(!clear_tiles, "R7 clear one cycle", clear_tiles, 0);
    do_store("R10 after palette 0");
    mk_valid(); cur[0] = 8'd0; cur[5] = 8'd3; send(1'b0, "R4 R7 palette 0 reserved");

    // R8 release
    mk_valid(); send(1'b0, "R2 before release");
    @(negedge clk); rel_cmd = 1'b1;
    @(negedge clk); rel_cmd = 1'b0;
    model_init();
    chk(clear_tiles, "R8 clear", clear_tiles, 1);
    check_cfg("R8 release");
    do_store("R10 after release");

    // R12 release on final beat
    mk_valid(); send(1'b0, "R2 before race");
    mk_valid(); send(1'b1, "R12 release with valid image");
    mk_valid(); send(1'b0, "R2 before race 2");
    mk_valid(); cur[0] = 8'd3; send(1'b1, "R12 release with bad image");

    // random mix
    for (int n = 0; n < 60; n++) begin
      int kind;
      mk_valid();
      kind = $urandom_range(6, 0);
      case (kind)
        3: cur[0] = 8'($urandom_range(255, 2));
        4: cur[$urandom_range(15, 2)] = 8'($urandom_range(255, 1));
        5: cur[48 + $urandom_range(7, 0)] = 8'($urandom_range(255, 17));
        6: cur[0] = 8'd0;
        default: ;
      endcase
      send(1'b0, "R1 R3 R4 R5 random");
      if (n % 5 == 0) do_store("R9 random store");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule